// File: doc/BRIEF.md
# Two-Stage Accumulator Processor Core

An 8-bit processor built around a single accumulator. Instructions live in a 32-word program store that is written through a load port. Working data lives in a 16-byte register-file memory. A fetch stage and an execute stage work on two successive instructions in the same cycle. The only register between them is the fetched instruction word: decode, operand selection, the ALU and the accumulator write all happen combinationally in the execute cycle.

Every instruction word is 12 bits. The opcode sits in bits [11:8] and an 8-bit operand field sits in bits [7:0]. The operand field is read in one of three ways:
- a data-memory address, using its low 4 bits;
- a literal, zero-padded to 8 bits;
- a short two's complement literal, taken from bits [4:0] and sign-extended.

Jumps are resolved in execute. By then the instruction ahead of the jump has retired, so its flags are already in the flag register. A taken jump discards the word being fetched and restarts fetch at the target. There is no prediction.

To use the core, hold the load enable high while writing the program, then release it. Execution starts at address 0. The accumulator, fetch address and flags are visible on debug outputs.

Top module: `acc_core`

## Requirements
- R1: While reset is low, the fetch address, accumulator and flags read zero. Data memory contents are not cleared by reset or by the load port.
- R2: While `ld_en` is high, each clock writes `ld_data` into program word `ld_addr`. On the following clock the core reads fetch address 0, accumulator 0 and flags 0, with no valid instruction in execute.
- R3: Take the first clock edge after `ld_en` falls as edge 1. The word at program address k changes the accumulator at edge k+2, when no jump intervenes. Without a taken jump, `pc_o` (the next fetch address) rises by one on every edge.
- R4: Pointer operands use field bits [3:0] as the data-memory address. LDM (2) loads that byte, ADM (5) adds it, SUB (6) subtracts it and AND (7) masks with it. STM (3) writes the accumulator there, and the very next instruction reads the stored value.
- R5: LDI (1), ADI (4) and XRI (10) use the 8-bit field as a zero-padded literal.
- R6: ADS (8) adds field bits [4:0] sign-extended to 8 bits. Field bits [7:5] have no effect.
- R7: SHS (9) shifts the accumulator by the signed amount in field bits [4:0]. A positive amount shifts left, a negative amount shifts right (logical), and a magnitude of 8 or more gives zero.
- R8: ALU operations (ADI, ADM, SUB, AND, ADS, SHS, XRI) write `flags_o`:
  - bit 0 = result is zero;
  - bit 1 = result bit 7;
  - bit 2 = carry out for additions, no-borrow for SUB, 0 for AND/XRI/SHS.
  All other opcodes leave the flags unchanged.
- R9: JMP (11) and every taken conditional jump load field bits [4:0] into the fetch address at their execute edge. The word fetched behind the jump is discarded, and the target's effect appears two edges after the jump's execute edge.
- R10: JZ (12), JN (13), JC (14) and JNZ (15) test zero, negative, carry and not-zero respectively. The test uses the flags as left by the preceding instruction. A jump that is not taken costs no cycle. NOP is opcode 0.
- R11: The fetch address wraps from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Program load enable; holds the core idle |
| ld_addr | input | 5 | Program word address for loading |
| ld_data | input | 12 | Program word to write |
| acc_o | output | 8 | Accumulator |
| pc_o | output | 5 | Next fetch address |
| flags_o | output | 3 | {carry, negative, zero} |

## Verification
Each table vector seeds one memory byte and the accumulator, then runs one operation. The vectors are chosen to separate the three operand readings:
- a negative short literal gives 0xFF under sign extension and 0x1F under zero padding;
- a field whose upper bits are set tells address and literal masking apart;
- shifts of +7, -2 and -8 separate direction and saturation.

Add, subtract-to-zero and subtract-with-borrow vectors pin the carry meaning. Directed programs then check:
- the edge on which each instruction lands;
- that a discarded word never reaches the accumulator;
- each jump condition, taken and not taken, straight after the flag-setting instruction;
- that loads leave flags intact, a store is read back on the next instruction, memory survives reset, and the fetch address wraps.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP = 4'd0,
      OP_LDI = 4'd1,
      OP_LDM = 4'd2,
      OP_STM = 4'd3,
      OP_ADI = 4'd4,
      OP_ADM = 4'd5,
      OP_SUB = 4'd6,
      OP_AND = 4'd7,
      OP_ADS = 4'd8,
      OP_SHS = 4'd9,
      OP_XRI = 4'd10,
      OP_JMP = 4'd11,
      OP_JZ  = 4'd12,
      OP_JN  = 4'd13,
      OP_JC  = 4'd14,
      OP_JNZ = 4'd15
   } opcode_e;

   // How the operand field is interpreted
   typedef enum logic [1:0] {
      SRC_NONE,
      SRC_MEM,
      SRC_ZIMM,
      SRC_SIMM
   } opsrc_e;

   typedef enum logic [2:0] {
      ALU_PASS,
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_XOR,
      ALU_SHIFT
   } alu_fn_e;

   typedef enum logic [2:0] {
      CND_ALW,
      CND_Z,
      CND_N,
      CND_C,
      CND_NZ
   } cond_e;

   typedef struct packed {
      opsrc_e  src;
      alu_fn_e fn;
      logic    acc_we;
      logic    flag_we;
      logic    mem_we;
      logic    is_jump;
      cond_e   cond;
   } ctrl_t;

   function automatic ctrl_t decode(opcode_e op);
      ctrl_t c;
      c = '{src: SRC_NONE, fn: ALU_PASS, acc_we: 1'b0, flag_we: 1'b0,
            mem_we: 1'b0, is_jump: 1'b0, cond: CND_ALW};
      case (op)
         OP_LDI: begin c.src = SRC_ZIMM; c.acc_we = 1'b1; end
         OP_LDM: begin c.src = SRC_MEM;  c.acc_we = 1'b1; end
         OP_STM: begin c.mem_we = 1'b1; end
         OP_ADI: begin c.src = SRC_ZIMM; c.fn = ALU_ADD;   c.acc_we = 1'b1; c.flag_we = 1'b1; end
         OP_ADM: begin c.src = SRC_MEM;  c.fn = ALU_ADD;   c.acc_we = 1'b1; c.flag_we = 1'b1; end
         OP_SUB: begin c.src = SRC_MEM;  c.fn = ALU_SUB;   c.acc_we = 1'b1; c.flag_we = 1'b1; end
         OP_AND: begin c.src = SRC_MEM;  c.fn = ALU_AND;   c.acc_we = 1'b1; c.flag_we = 1'b1; end
         OP_ADS: begin c.src = SRC_SIMM; c.fn = ALU_ADD;   c.acc_we = 1'b1; c.flag_we = 1'b1; end
         OP_SHS: begin c.src = SRC_NONE; c.fn = ALU_SHIFT; c.acc_we = 1'b1; c.flag_we = 1'b1; end
         OP_XRI: begin c.src = SRC_ZIMM; c.fn = ALU_XOR;   c.acc_we = 1'b1; c.flag_we = 1'b1; end
         OP_JMP: begin c.is_jump = 1'b1; c.cond = CND_ALW; end
         OP_JZ:  begin c.is_jump = 1'b1; c.cond = CND_Z;   end
         OP_JN:  begin c.is_jump = 1'b1; c.cond = CND_N;   end
         OP_JC:  begin c.is_jump = 1'b1; c.cond = CND_C;   end
         OP_JNZ: begin c.is_jump = 1'b1; c.cond = CND_NZ;  end
         default: ;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/acc_fetch.sv
module acc_fetch #(
   parameter int PROG_DEPTH = 32,
   parameter int INSTR_W    = 12,
   localparam int PC_W      = $clog2(PROG_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_en,
   input  logic [PC_W-1:0]    ld_addr,
   input  logic [INSTR_W-1:0] ld_data,
   input  logic               redirect,
   input  logic [PC_W-1:0]    redirect_pc,
   output logic [PC_W-1:0]    pc_o,
   output logic [INSTR_W-1:0] ir_o,
   output logic               ir_valid_o
);

   logic [INSTR_W-1:0] prog_mem [PROG_DEPTH];
   logic [PC_W-1:0]    pc_q;
   logic [INSTR_W-1:0] ir_q;
   logic               valid_q;

   always_ff @(posedge clk) begin
      if (ld_en) prog_mem[ld_addr] <= ld_data;
   end

   // Fetch register: the only boundary between the two stages
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         ir_q    <= '0;
         valid_q <= 1'b0;
      end else if (ld_en) begin
         pc_q    <= '0;
         ir_q    <= '0;
         valid_q <= 1'b0;
      end else if (redirect) begin
         pc_q    <= redirect_pc;
         valid_q <= 1'b0;
      end else begin
         pc_q    <= pc_q + 1'b1;
         ir_q    <= prog_mem[pc_q];
         valid_q <= 1'b1;
      end
   end

   assign pc_o       = pc_q;
   assign ir_o       = ir_q;
   assign ir_valid_o = valid_q;

endmodule

// File: rtl/acc_dmem.sv
module acc_dmem #(
   parameter int DATA_W     = 8,
   parameter int DMEM_DEPTH = 16,
   localparam int AW        = $clog2(DMEM_DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] cells [DMEM_DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
   end

   assign rdata = cells[addr];

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_core_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SIMM_W = 5,
   localparam int ST    = $clog2(DATA_W)
) (
   input  alu_fn_e           fn,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [SIMM_W-1:0] shamt,
   output logic [DATA_W-1:0] res,
   output logic              carry
);

   // Adder shared by add and subtract
   logic [DATA_W:0]   sum;
   logic [DATA_W-1:0] b_eff;
   logic              cin;

   always_comb begin
      b_eff = (fn == ALU_SUB) ? ~b : b;
      cin   = (fn == ALU_SUB);
      sum   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
   end

   // Bidirectional barrel shifter: reverse, shift left, reverse
   logic              neg;
   logic [SIMM_W-1:0] mag;
   logic              too_far;
   logic [DATA_W-1:0] a_rev;
   logic [DATA_W-1:0] stg [ST+1];
   logic [DATA_W-1:0] sh_fwd;
   logic [DATA_W-1:0] sh_rev;
   logic [DATA_W-1:0] sh_out;

   assign neg     = shamt[SIMM_W-1];
   assign mag     = neg ? (~shamt + 1'b1) : shamt;
   assign too_far = |mag[SIMM_W-1:ST];

   for (genvar r = 0; r < DATA_W; r++) begin : g_rev
      assign a_rev[r]  = a[DATA_W-1-r];
      assign sh_rev[r] = sh_fwd[DATA_W-1-r];
   end

   assign stg[0] = neg ? a_rev : a;

   for (genvar s = 0; s < ST; s++) begin : g_stage
      assign stg[s+1] = mag[s] ? (stg[s] << (2**s)) : stg[s];
   end

   assign sh_fwd = too_far ? '0 : stg[ST];
   assign sh_out = neg ? sh_rev : sh_fwd;

   always_comb begin
      res   = b;
      carry = 1'b0;
      case (fn)
         ALU_ADD, ALU_SUB: begin res = sum[DATA_W-1:0]; carry = sum[DATA_W]; end
         ALU_AND:   res = a & b;
         ALU_XOR:   res = a ^ b;
         ALU_SHIFT: res = sh_out;
         default:   res = b;
      endcase
   end

endmodule

// File: rtl/acc_core.sv
module acc_core
   import acc_core_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int DMEM_DEPTH = 16,
   parameter int PROG_DEPTH = 32,
   parameter int SIMM_W     = 5,
   localparam int PC_W      = $clog2(PROG_DEPTH),
   localparam int AW        = $clog2(DMEM_DEPTH),
   localparam int INSTR_W   = OPC_W + DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_en,
   input  logic [PC_W-1:0]    ld_addr,
   input  logic [INSTR_W-1:0] ld_data,
   output logic [DATA_W-1:0]  acc_o,
   output logic [PC_W-1:0]    pc_o,
   output logic [2:0]         flags_o
);

   // Elaboration-time parameter checks
   if (DATA_W < PC_W) begin : g_err_pc
      $error("DATA_W must hold a jump target");
   end
   if (DATA_W < AW) begin : g_err_aw
      $error("DATA_W must hold a data address");
   end
   if (SIMM_W <= $clog2(DATA_W) || SIMM_W > DATA_W) begin : g_err_simm
      $error("SIMM_W out of range");
   end
   if ((1 << PC_W) != PROG_DEPTH) begin : g_err_prog
      $error("PROG_DEPTH must be a power of two");
   end
   if ((1 << AW) != DMEM_DEPTH) begin : g_err_dmem
      $error("DMEM_DEPTH must be a power of two");
   end

   logic [INSTR_W-1:0] ir;
   logic               ir_valid;
   opcode_e            op;
   logic [DATA_W-1:0]  fld;
   ctrl_t              ctrl;
   logic [DATA_W-1:0]  operand;
   logic [DATA_W-1:0]  mem_rd;
   logic [DATA_W-1:0]  alu_res;
   logic               alu_c;
   logic               take;
   logic [PC_W-1:0]    tgt;
   logic [DATA_W-1:0]  acc_q;
   logic               fz_q, fn_q, fc_q;

   acc_fetch #(
      .PROG_DEPTH (PROG_DEPTH),
      .INSTR_W    (INSTR_W)
   ) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_en       (ld_en),
      .ld_addr     (ld_addr),
      .ld_data     (ld_data),
      .redirect    (take),
      .redirect_pc (tgt),
      .pc_o        (pc_o),
      .ir_o        (ir),
      .ir_valid_o  (ir_valid)
   );

   // Execute: decode straight off the fetch register
   assign op   = opcode_e'(ir[INSTR_W-1 -: OPC_W]);
   assign fld  = ir[DATA_W-1:0];
   assign ctrl = (ir_valid && !ld_en) ? decode(op) : decode(OP_NOP);
   assign tgt  = fld[PC_W-1:0];

   acc_dmem #(
      .DATA_W     (DATA_W),
      .DMEM_DEPTH (DMEM_DEPTH)
   ) u_dmem (
      .clk   (clk),
      .we    (ctrl.mem_we),
      .addr  (fld[AW-1:0]),
      .wdata (acc_q),
      .rdata (mem_rd)
   );

   always_comb begin
      case (ctrl.src)
         SRC_MEM:  operand = mem_rd;
         SRC_ZIMM: operand = fld;
         SRC_SIMM: operand = {{(DATA_W-SIMM_W){fld[SIMM_W-1]}}, fld[SIMM_W-1:0]};
         default:  operand = '0;
      endcase
   end

   acc_alu #(
      .DATA_W (DATA_W),
      .SIMM_W (SIMM_W)
   ) u_alu (
      .fn    (ctrl.fn),
      .a     (acc_q),
      .b     (operand),
      .shamt (fld[SIMM_W-1:0]),
      .res   (alu_res),
      .carry (alu_c)
   );

   always_comb begin
      take = 1'b0;
      if (ctrl.is_jump) begin
         case (ctrl.cond)
            CND_ALW: take = 1'b1;
            CND_Z:   take = fz_q;
            CND_N:   take = fn_q;
            CND_C:   take = fc_q;
            CND_NZ:  take = !fz_q;
            default: take = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         fz_q  <= 1'b0;
         fn_q  <= 1'b0;
         fc_q  <= 1'b0;
      end else if (ld_en) begin
         acc_q <= '0;
         fz_q  <= 1'b0;
         fn_q  <= 1'b0;
         fc_q  <= 1'b0;
      end else begin
         if (ctrl.acc_we) acc_q <= alu_res;
         if (ctrl.flag_we) begin
            fz_q <= (alu_res == '0);
            fn_q <= alu_res[DATA_W-1];
            fc_q <= alu_c;
         end
      end
   end

   assign acc_o   = acc_q;
   assign flags_o = {fc_q, fn_q, fz_q};

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
   import acc_core_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PC_W   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_en,
   input logic [PC_W-1:0]   pc_o,
   input logic [DATA_W-1:0] acc_o,
   input logic [2:0]        flags_o,
   input logic              ir_valid,
   input logic [3:0]        op,
   input logic              take,
   input logic [PC_W-1:0]   tgt
);

   logic keeps_flags;
   logic alu_op;

   assign keeps_flags = !ir_valid ||
      (op inside {OP_NOP, OP_LDI, OP_LDM, OP_STM, OP_JMP, OP_JZ, OP_JN, OP_JC, OP_JNZ});
   assign alu_op = ir_valid && !keeps_flags;

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (pc_o == '0 && acc_o == '0 && flags_o == '0));

   assert_load_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (pc_o == '0 && !ir_valid && acc_o == '0 && flags_o == '0));

   // Also covers R11: the step wraps in PC_W bits
   assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !take) |=> pc_o == PC_W'($past(pc_o) + 1'b1));

   assert_flags_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && keeps_flags) |=> $stable(flags_o));

   assert_zn_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && alu_op) |=> (flags_o[0] == (acc_o == '0) && flags_o[1] == acc_o[DATA_W-1]));

   assert_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && take) |=> (pc_o == $past(tgt) && !ir_valid));

   assert_jz_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && ir_valid && op == OP_JZ) |-> take == flags_o[0]);

   assert_jnz_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && ir_valid && op == OP_JNZ) |-> take == !flags_o[0]);

endmodule

bind acc_core acc_core_chk #(
   .DATA_W (DATA_W),
   .PC_W   (PC_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ld_en    (ld_en),
   .pc_o     (pc_o),
   .acc_o    (acc_o),
   .flags_o  (flags_o),
   .ir_valid (ir_valid),
   .op       (op),
   .take     (take),
   .tgt      (tgt)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/100ps
module acc_core_bench;

   localparam logic [3:0] NOP = 4'd0,  LDI = 4'd1,  LDM = 4'd2,  STM = 4'd3,
                          ADI = 4'd4,  ADM = 4'd5,  SUB = 4'd6,  ANDM = 4'd7,
                          ADS = 4'd8,  SHS = 4'd9,  XRI = 4'd10, JMP = 4'd11,
                          JZ  = 4'd12, JN  = 4'd13, JC  = 4'd14, JNZ = 4'd15;

   typedef struct packed {
      logic [3:0] op;
      logic [7:0] fld;
      logic [7:0] a;
      logic [7:0] m;
      logic [7:0] exp_acc;
      logic [2:0] exp_fl;   // {C,N,Z}
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{ADI,  8'h10, 8'hF8, 8'h00, 8'h08, 3'b100},  // R5 R8 carry out
      '{ADM,  8'h05, 8'h7F, 8'h01, 8'h80, 3'b010},  // R4 R8 negative
      '{SUB,  8'h05, 8'h05, 8'h05, 8'h00, 3'b101},  // R4 R8 zero, no borrow
      '{SUB,  8'h05, 8'h03, 8'h05, 8'hFE, 3'b010},  // R4 R8 borrow
      '{ANDM, 8'h05, 8'hF0, 8'h3C, 8'h30, 3'b000},  // R4
      '{ADS,  8'h1F, 8'h00, 8'h00, 8'hFF, 3'b010},  // R6 sign extension
      '{ADS,  8'hEF, 8'h01, 8'h00, 8'h10, 3'b000},  // R6 upper bits ignored
      '{SHS,  8'h03, 8'h81, 8'h00, 8'h08, 3'b000},  // R7 left
      '{SHS,  8'h1E, 8'h81, 8'h00, 8'h20, 3'b000},  // R7 right by 2
      '{SHS,  8'h18, 8'hFF, 8'h00, 8'h00, 3'b001},  // R7 saturate at -8
      '{SHS,  8'h07, 8'h01, 8'h00, 8'h80, 3'b010},  // R7 left by 7
      '{XRI,  8'hFF, 8'h5A, 8'h00, 8'hA5, 3'b010},  // R5
      '{LDM,  8'hF5, 8'h11, 8'h9C, 8'h9C, 3'b000},  // R4 address masking, R8 no flag write
      '{ADI,  8'h00, 8'h00, 8'h00, 8'h00, 3'b001}   // R8 zero
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic [4:0]  ld_addr = '0;
   logic [11:0] ld_data = '0;
   logic [7:0]  acc_o;
   logic [4:0]  pc_o;
   logic [2:0]  flags_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [11:0] prog [32];

   always #2.5 clk = ~clk;

   acc_core u_acc_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .ld_addr (ld_addr),
      .ld_data (ld_data),
      .acc_o   (acc_o),
      .pc_o    (pc_o),
      .flags_o (flags_o)
   );

   function automatic logic [11:0] w(logic [3:0] op, logic [7:0] fld);
      return {op, fld};
   endfunction

   task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic clr_prog();
      for (int i = 0; i < 32; i++) prog[i] = w(NOP, 8'h00);
   endtask

   // Writes all 32 words, then releases ld_en right after the last edge
   task automatic load_prog();
      ld_en = 1'b1;
      for (int i = 0; i < 32; i++) begin
         ld_addr = 5'(i);
         ld_data = prog[i];
         tick(1);
      end
      ld_en = 1'b0;
   endtask

   task automatic jump_prog(logic [11:0] w0, logic [11:0] w1, logic [11:0] w2);
      clr_prog();
      prog[0] = w0;
      prog[1] = w1;
      prog[2] = w2;
      prog[3] = w(LDI, 8'h77);
      prog[4] = w(JMP, 8'h04);
      prog[8] = w(LDI, 8'h42);
      prog[9] = w(JMP, 8'h09);
      load_prog();
      tick(14);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL all watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1;
      chk("R1", "acc in reset", acc_o, 8'h00);
      chk("R1", "pc in reset", {3'b0, pc_o}, 8'h00);
      chk("R1", "flags in reset", {5'b0, flags_o}, 8'h00);
      tick(2);
      rst_n = 1'b1;
      tick(1);

      // Table walk
      for (int v = 0; v < NV; v++) begin
         clr_prog();
         prog[0] = w(LDI, VECS[v].m);
         prog[1] = w(STM, 8'h05);
         prog[2] = w(LDI, VECS[v].a);
         prog[3] = w(VECS[v].op, VECS[v].fld);
         prog[4] = w(JMP, 8'h04);
         load_prog();
         tick(8);
         chk($sformatf("vec%0d", v), "acc", acc_o, VECS[v].exp_acc);
         chk($sformatf("vec%0d", v), "flags", {5'b0, flags_o}, {5'b0, VECS[v].exp_fl});
      end

      // R2: loading clears the running state left by the last vector
      clr_prog();
      prog[0] = w(LDI, 8'h11);
      prog[1] = w(LDI, 8'h22);
      prog[2] = w(LDI, 8'h33);
      prog[3] = w(JMP, 8'h03);
      ld_en = 1'b1;
      ld_addr = 5'd31;
      ld_data = w(NOP, 8'h00);
      tick(1);
      chk("R2", "acc held", acc_o, 8'h00);
      chk("R2", "pc held", {3'b0, pc_o}, 8'h00);
      chk("R2", "flags held", {5'b0, flags_o}, 8'h00);

      // R3: stage overlap timing
      load_prog();
      tick(1);
      chk("R3", "edge1 acc", acc_o, 8'h00);
      chk("R3", "edge1 pc", {3'b0, pc_o}, 8'h01);
      tick(1);
      chk("R3", "edge2 acc", acc_o, 8'h11);
      chk("R3", "edge2 pc", {3'b0, pc_o}, 8'h02);
      tick(1);
      chk("R3", "edge3 acc", acc_o, 8'h22);

      // R9: taken jump, discarded word, target timing
      clr_prog();
      prog[0] = w(LDI, 8'h01);
      prog[1] = w(JMP, 8'h06);
      prog[2] = w(LDI, 8'hEE);
      prog[6] = w(ADI, 8'h02);
      prog[7] = w(JMP, 8'h07);
      load_prog();
      tick(3);
      chk("R9", "pc after jump", {3'b0, pc_o}, 8'h06);
      chk("R9", "acc after jump", acc_o, 8'h01);
      tick(1);
      chk("R9", "discarded word", acc_o, 8'h01);
      chk("R9", "pc resumes", {3'b0, pc_o}, 8'h07);
      tick(1);
      chk("R9", "target executed", acc_o, 8'h03);

      // R10: conditions right behind the flag-setting instruction
      jump_prog(w(ADI, 8'h00), w(JZ, 8'h08), w(NOP, 8'h00));
      chk("R10", "JZ taken", acc_o, 8'h42);
      jump_prog(w(ADI, 8'h01), w(JZ, 8'h08), w(NOP, 8'h00));
      chk("R10", "JZ not taken", acc_o, 8'h77);
      jump_prog(w(ADI, 8'h80), w(JN, 8'h08), w(NOP, 8'h00));
      chk("R10", "JN taken", acc_o, 8'h42);
      jump_prog(w(LDI, 8'hFF), w(ADI, 8'h01), w(JC, 8'h08));
      chk("R10", "JC taken", acc_o, 8'h42);
      jump_prog(w(ADI, 8'h00), w(JNZ, 8'h08), w(NOP, 8'h00));
      chk("R10", "JNZ not taken", acc_o, 8'h77);
      jump_prog(w(ADI, 8'h01), w(JNZ, 8'h08), w(NOP, 8'h00));
      chk("R10", "JNZ taken", acc_o, 8'h42);
      // R8: a load between the ALU op and the jump keeps Z
      jump_prog(w(ADI, 8'h00), w(LDI, 8'h05), w(JZ, 8'h08));
      chk("R8", "LDI kept flags", acc_o, 8'h42);

      // R4: stored byte read by the next instruction
      clr_prog();
      prog[0] = w(LDI, 8'h3C);
      prog[1] = w(STM, 8'h09);
      prog[2] = w(ADM, 8'h09);
      prog[3] = w(JMP, 8'h03);
      load_prog();
      tick(8);
      chk("R4", "store then add", acc_o, 8'h78);

      // R1: data memory survives reset
      rst_n = 1'b0;
      #1;
      chk("R1", "async clear acc", acc_o, 8'h00);
      chk("R1", "async clear pc", {3'b0, pc_o}, 8'h00);
      tick(1);
      rst_n = 1'b1;
      clr_prog();
      prog[0] = w(LDM, 8'h09);
      prog[1] = w(JMP, 8'h01);
      load_prog();
      tick(6);
      chk("R1", "memory kept", acc_o, 8'h3C);

      // R11: fetch address wraps
      clr_prog();
      prog[31] = w(LDI, 8'h99);
      load_prog();
      tick(31);
      chk("R11", "pc at 31", {3'b0, pc_o}, 8'h1F);
      tick(1);
      chk("R11", "pc wrapped", {3'b0, pc_o}, 8'h00);
      tick(1);
      chk("R11", "pc after wrap", {3'b0, pc_o}, 8'h01);
      chk("R11", "last word executed", acc_o, 8'h99);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule